// File: doc/BRIEF.md
# Touch Acquisition Sequencer

This block sets the pace of a capacitive touch front end. After reset it runs a fixed power-up sequence. A short marker pulse overrides one of the key outputs. Once a longer wait has passed, the block issues a calibration request. From then on it loops: it sleeps, waits a short settle time after waking, and then requests an acquisition. It waits for the measurement engine to report completion before it starts the next sleep. A speed strap picks a short or a long sleep interval. At power-up the block reads a debug-entry sense input, and after a long window it checks that input again to decide whether key 3 must be flagged as stuck.

The sequencer does not measure anything and makes no touch decisions. It only produces one-cycle request strobes, a marker override and two mode flags. The detector can ask for a recalibration at any time after power-up, and the sequencer then returns to its calibration step without running the marker again. Every interval is set in microseconds (the marker width in nanoseconds) and converted to clock cycles from the clock-frequency parameter.

Top module: `acq_sequencer`

## Requirements
- R1: While rst_ni is low, every output is 0.
- R2: Counting clock edges after reset release as k = 1, 2, ..., marker_o is 1 exactly for MARK_AT <= k < MARK_AT + MARK_W, and never again until the next reset.
- R3: cal_req_o is a one-cycle strobe that is high at k = CAL_AT. No other power-up strobe occurs.
- R4: When acq_done_i is sampled high on an edge while a calibration or acquisition result is pending, acq_req_o pulses for one cycle exactly SLEEP + SETTLE edges later. SLEEP is the fast or the slow interval and SETTLE is the wake-settle delay.
- R5: The speed strap is captured on the first clock edge after reset release (1 = fast, 0 = slow). Later changes of fast_strap_i have no effect on the sleep length.
- R6: acq_done_i has no effect unless a request is pending. A pulse during boot or sleep does not shift any later strobe.
- R7: dbg_mode_o takes the value dbg_sense_i has on the first edge after reset release and keeps that value until the next reset.
- R8: If debug mode is on and dbg_sense_i is still 1 on edge k = DBG_WIN, key3_stuck_o becomes 1 from that edge. It returns to 0 on the edge that starts the next calibration request.
- R9: recal_i sampled high in any state other than boot or the calibration-strobe cycle makes cal_req_o high after that edge, and the marker is not repeated. During boot recal_i is ignored.
- R10: cal_req_o and acq_req_o are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| fast_strap_i | input | 1 | Speed strap, 1 = short sleep |
| dbg_sense_i | input | 1 | Debug-entry condition |
| acq_done_i | input | 1 | Calibration or acquisition finished |
| recal_i | input | 1 | Recalibration request from the detector |
| cal_req_o | output | 1 | One-cycle calibration request |
| acq_req_o | output | 1 | One-cycle acquisition request |
| dbg_mode_o | output | 1 | Debug mode active |
| key3_stuck_o | output | 1 | Key 3 held as stuck until recalibration |
| marker_o | output | 1 | Power-up marker override for output 2 |

## Verification
The marker, the power-up calibration strobe and the stuck flag are all due at a fixed count of edges after reset release. The bench keeps its own edge counter and compares every output against that count at each falling edge. The acquisition strobe is due exactly SLEEP + SETTLE edges after the edge that takes in acq_done_i, and a recalibration strobe is due on the edge that takes in recal_i. Each wait loop in the bench counts exactly those edges and samples half a cycle after the last one. The bench runs all eight combinations of strap, debug entry and debug hold, so both sleep lengths and both stuck outcomes are covered.

// File: rtl/acq_seq_pkg.sv
package acq_seq_pkg;

  typedef enum logic [2:0] {
    ST_BOOT,
    ST_CAL_REQ,
    ST_CAL_WAIT,
    ST_SLEEP,
    ST_SETTLE,
    ST_ACQ_REQ,
    ST_ACQ_WAIT
  } seq_state_e;

  function automatic longint us_to_cyc(longint clk_hz, longint us);
    longint c;
    c = (clk_hz * us) / 64'd1_000_000;
    return (c < 1) ? 64'd1 : c;
  endfunction

  function automatic longint ns_to_cyc(longint clk_hz, longint ns);
    longint c;
    c = (clk_hz * ns) / 64'd1_000_000_000;
    return (c < 1) ? 64'd1 : c;
  endfunction

endpackage

// File: rtl/seq_timer.sv
module seq_timer #(
  parameter int unsigned W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic [W-1:0] load_val_i,
  output logic         zero_o
);

  logic [W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)             cnt_q <= '0;
    else if (load_i)         cnt_q <= load_val_i;
    else if (cnt_q != '0)    cnt_q <= cnt_q - 1'b1;
  end

  assign zero_o = (cnt_q == '0);

endmodule

// File: rtl/pu_ctrl.sv
module pu_ctrl #(
  parameter int unsigned PU_W     = 8,
  parameter int unsigned PU_MAX   = 200,
  parameter int unsigned MARK_AT  = 80,
  parameter int unsigned MARK_W   = 2,
  parameter int unsigned CAL_AT   = 200,
  parameter int unsigned DBG_WIN  = 200
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic fast_strap_i,
  input  logic dbg_sense_i,
  input  logic stuck_clr_i,
  output logic fast_o,
  output logic dbg_mode_o,
  output logic key3_stuck_o,
  output logic marker_o,
  output logic cal_due_o
);

  localparam logic [PU_W-1:0] L_MAX   = PU_W'(PU_MAX);
  localparam logic [PU_W-1:0] L_MA    = PU_W'(MARK_AT);
  localparam logic [PU_W-1:0] L_ME    = PU_W'(MARK_AT + MARK_W);
  localparam logic [PU_W-1:0] L_CAL   = PU_W'(CAL_AT - 1);
  localparam logic [PU_W-1:0] L_DBG   = PU_W'(DBG_WIN - 1);

  logic [PU_W-1:0] pu_cnt_q;
  logic            first;
  logic            fast_q, dbg_q, stuck_q;

  assign first = (pu_cnt_q == '0);

  // free-running power-up time base, saturates once every milestone is past
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                 pu_cnt_q <= '0;
    else if (pu_cnt_q != L_MAX)  pu_cnt_q <= pu_cnt_q + 1'b1;
  end

  // straps captured on the edge that ends reset
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      fast_q <= 1'b0;
      dbg_q  <= 1'b0;
    end else if (first) begin
      fast_q <= fast_strap_i;
      dbg_q  <= dbg_sense_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                                            stuck_q <= 1'b0;
    else if (stuck_clr_i)                                   stuck_q <= 1'b0;
    else if (pu_cnt_q == L_DBG && dbg_q && dbg_sense_i)     stuck_q <= 1'b1;
  end

  assign marker_o     = (pu_cnt_q >= L_MA) && (pu_cnt_q < L_ME);
  assign cal_due_o    = (pu_cnt_q == L_CAL);
  assign fast_o       = fast_q;
  assign dbg_mode_o   = dbg_q;
  assign key3_stuck_o = stuck_q;

endmodule

// File: rtl/seq_fsm.sv
module seq_fsm
  import acq_seq_pkg::*;
#(
  parameter int unsigned TW       = 8,
  parameter int unsigned FAST_C   = 64,
  parameter int unsigned SLOW_C   = 256,
  parameter int unsigned SETTLE_C = 20
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          cal_due_i,
  input  logic          fast_i,
  input  logic          acq_done_i,
  input  logic          recal_i,
  input  logic          tmr_zero_i,
  output logic          tmr_load_o,
  output logic [TW-1:0] tmr_val_o,
  output logic          cal_start_o,
  output logic          cal_req_o,
  output logic          acq_req_o
);

  localparam logic [TW-1:0] L_FAST   = TW'(FAST_C - 1);
  localparam logic [TW-1:0] L_SLOW   = TW'(SLOW_C - 1);
  localparam logic [TW-1:0] L_SETTLE = TW'(SETTLE_C - 1);

  seq_state_e state_q, state_d;

  always_comb begin
    state_d    = state_q;
    tmr_load_o = 1'b0;
    unique case (state_q)
      ST_BOOT:     if (cal_due_i) state_d = ST_CAL_REQ;
      ST_CAL_REQ:  state_d = ST_CAL_WAIT;
      ST_CAL_WAIT: if (acq_done_i) begin state_d = ST_SLEEP; tmr_load_o = 1'b1; end
      ST_SLEEP:    if (tmr_zero_i) begin state_d = ST_SETTLE; tmr_load_o = 1'b1; end
      ST_SETTLE:   if (tmr_zero_i) state_d = ST_ACQ_REQ;
      ST_ACQ_REQ:  state_d = ST_ACQ_WAIT;
      ST_ACQ_WAIT: if (acq_done_i) begin state_d = ST_SLEEP; tmr_load_o = 1'b1; end
      default:     state_d = ST_BOOT;
    endcase
    // detector recalibration overrides the loop once power-up is over
    if (recal_i && state_q != ST_BOOT && state_q != ST_CAL_REQ) begin
      state_d    = ST_CAL_REQ;
      tmr_load_o = 1'b0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= ST_BOOT;
    else         state_q <= state_d;
  end

  assign tmr_val_o   = (state_q == ST_SLEEP) ? L_SETTLE : (fast_i ? L_FAST : L_SLOW);
  assign cal_start_o = (state_d == ST_CAL_REQ) && (state_q != ST_CAL_REQ);
  assign cal_req_o   = (state_q == ST_CAL_REQ);
  assign acq_req_o   = (state_q == ST_ACQ_REQ);

endmodule

// File: rtl/acq_sequencer.sv
module acq_sequencer
  import acq_seq_pkg::*;
#(
  parameter int unsigned CLK_HZ        = 32_000_000,
  parameter int unsigned MARK_AT_US    = 20_000,
  parameter int unsigned MARK_NS       = 500,
  parameter int unsigned CAL_AT_US     = 50_000,
  parameter int unsigned FAST_SLEEP_US = 16_000,
  parameter int unsigned SLOW_SLEEP_US = 64_000,
  parameter int unsigned SETTLE_US     = 500,
  parameter int unsigned DBG_WIN_US    = 5_000_000
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic fast_strap_i,
  input  logic dbg_sense_i,
  input  logic acq_done_i,
  input  logic recal_i,
  output logic cal_req_o,
  output logic acq_req_o,
  output logic dbg_mode_o,
  output logic key3_stuck_o,
  output logic marker_o
);

  localparam int unsigned MARK_AT_C = int'(us_to_cyc(CLK_HZ, MARK_AT_US));
  localparam int unsigned MARK_W_C  = int'(ns_to_cyc(CLK_HZ, MARK_NS));
  localparam int unsigned CAL_C     = int'(us_to_cyc(CLK_HZ, CAL_AT_US));
  localparam int unsigned FAST_C    = int'(us_to_cyc(CLK_HZ, FAST_SLEEP_US));
  localparam int unsigned SLOW_C    = int'(us_to_cyc(CLK_HZ, SLOW_SLEEP_US));
  localparam int unsigned SETTLE_C  = int'(us_to_cyc(CLK_HZ, SETTLE_US));
  localparam int unsigned DBG_C     = int'(us_to_cyc(CLK_HZ, DBG_WIN_US));
  localparam int unsigned MARK_E_C  = MARK_AT_C + MARK_W_C;
  localparam int unsigned PU_MAX0   = (CAL_C > DBG_C) ? CAL_C : DBG_C;
  localparam int unsigned PU_MAX    = (PU_MAX0 > MARK_E_C) ? PU_MAX0 : MARK_E_C;
  localparam int unsigned PU_W      = $clog2(PU_MAX + 1);
  localparam int unsigned T_MAX0    = (FAST_C > SLOW_C) ? FAST_C : SLOW_C;
  localparam int unsigned T_MAX     = (T_MAX0 > SETTLE_C) ? T_MAX0 : SETTLE_C;
  localparam int unsigned TW        = $clog2(T_MAX + 1);

  logic          fast_q, cal_due, cal_start;
  logic          tmr_load, tmr_zero;
  logic [TW-1:0] tmr_val;

  pu_ctrl #(
    .PU_W    (PU_W),
    .PU_MAX  (PU_MAX),
    .MARK_AT (MARK_AT_C),
    .MARK_W  (MARK_W_C),
    .CAL_AT  (CAL_C),
    .DBG_WIN (DBG_C)
  ) u_pu (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .fast_strap_i (fast_strap_i),
    .dbg_sense_i  (dbg_sense_i),
    .stuck_clr_i  (cal_start),
    .fast_o       (fast_q),
    .dbg_mode_o   (dbg_mode_o),
    .key3_stuck_o (key3_stuck_o),
    .marker_o     (marker_o),
    .cal_due_o    (cal_due)
  );

  seq_fsm #(
    .TW       (TW),
    .FAST_C   (FAST_C),
    .SLOW_C   (SLOW_C),
    .SETTLE_C (SETTLE_C)
  ) u_fsm (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .cal_due_i   (cal_due),
    .fast_i      (fast_q),
    .acq_done_i  (acq_done_i),
    .recal_i     (recal_i),
    .tmr_zero_i  (tmr_zero),
    .tmr_load_o  (tmr_load),
    .tmr_val_o   (tmr_val),
    .cal_start_o (cal_start),
    .cal_req_o   (cal_req_o),
    .acq_req_o   (acq_req_o)
  );

  seq_timer #(.W(TW)) u_tmr (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_i     (tmr_load),
    .load_val_i (tmr_val),
    .zero_o     (tmr_zero)
  );

endmodule

// File: rtl/acq_seq_chk.sv
module acq_seq_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic recal_i,
  input logic cal_req_o,
  input logic acq_req_o,
  input logic dbg_mode_o,
  input logic key3_stuck_o,
  input logic marker_o
);

  logic       mk_prev, mk_done;
  logic [1:0] age;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mk_prev <= 1'b0;
      mk_done <= 1'b0;
      age     <= '0;
    end else begin
      mk_prev <= marker_o;
      if (mk_prev && !marker_o) mk_done <= 1'b1;
      if (age != 2'd3) age <= age + 1'b1;
    end
  end

  p_req_excl_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({cal_req_o, acq_req_o}));

  p_acq_pulse_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acq_req_o |=> !acq_req_o);

  p_cal_pulse_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cal_req_o |=> !cal_req_o);

  p_marker_once_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mk_done |-> !marker_o);

  p_dbg_hold_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (age >= 2'd2) |-> $stable(dbg_mode_o));

  p_stuck_dbg_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(key3_stuck_o) |-> dbg_mode_o);

  p_recal_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (recal_i && acq_req_o) |=> cal_req_o);

endmodule

bind acq_sequencer acq_seq_chk u_chk (.*);

// File: tb/acq_sequencer_bench.sv
module acq_sequencer_bench;

  localparam int MA  = 80;
  localparam int MW  = 2;
  localparam int CAL = 200;
  localparam int FN  = 64;
  localparam int SN  = 256;
  localparam int SET = 20;
  localparam int DBG = 400;

  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic fast_strap_i = 1'b0, dbg_sense_i = 1'b0, acq_done_i = 1'b0, recal_i = 1'b0;
  logic cal_req_o, acq_req_o, dbg_mode_o, key3_stuck_o, marker_o;

  int n_chk = 0, n_fail = 0, k = 0;
  bit cfg_fast, cfg_dbg, cfg_hold, cleared, finished = 1'b0;

  always #10 clk_i = ~clk_i;

  acq_sequencer #(
    .CLK_HZ(4_000_000), .MARK_AT_US(20), .MARK_NS(500), .CAL_AT_US(50),
    .FAST_SLEEP_US(16), .SLOW_SLEEP_US(64), .SETTLE_US(5), .DBG_WIN_US(100)
  ) u_acq_sequencer (.*);

  task automatic chk(input string req, input logic act, input logic exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s k=%0d actual=%b expected=%b (fast=%0b dbg=%0b hold=%0b)",
               req, k, act, exp, cfg_fast, cfg_dbg, cfg_hold);
    end
  endtask

  task automatic step(input logic ec, input logic ea);
    @(posedge clk_i); k++;
    @(negedge clk_i);
    chk("R2 marker", marker_o, (k >= MA) && (k < MA + MW));
    chk("R7 dbg_mode", dbg_mode_o, cfg_dbg);
    chk("R8 key3_stuck", key3_stuck_o, cfg_dbg && cfg_hold && (k >= DBG) && !cleared);
    chk("R3/R9 cal_req", cal_req_o, ec);
    chk("R4/R5/R6 acq_req", acq_req_o, ea);
    chk("R10 exclusive", cal_req_o && acq_req_o, 1'b0);
  endtask

  // done pulse, then sleep+settle with a stray done inside sleep (R6)
  task automatic acq_cycle();
    int n;
    n = cfg_fast ? FN : SN;
    acq_done_i = 1'b1; step(1'b0, 1'b0); acq_done_i = 1'b0;
    for (int j = 1; j <= n + SET + 1; j++) begin
      if (j == 3) acq_done_i = 1'b1;
      step(1'b0, j == n + SET);
      acq_done_i = 1'b0;
    end
  endtask

  initial begin
    for (int f = 0; f < 2; f++) begin
      for (int d = 0; d < 2; d++) begin
        for (int h = 0; h < 2; h++) begin
          cfg_fast = f[0]; cfg_dbg = d[0]; cfg_hold = h[0]; cleared = 1'b0;
          rst_ni = 1'b0; fast_strap_i = cfg_fast; dbg_sense_i = cfg_dbg;
          repeat (2) @(posedge clk_i);
          @(negedge clk_i);
          chk("R1 reset", cal_req_o | acq_req_o | dbg_mode_o | key3_stuck_o | marker_o, 1'b0);
          rst_ni = 1'b1; k = 0;
          // boot: strap flipped after capture (R5), stray recal and done ignored (R9, R6)
          for (int i = 1; i <= CAL; i++) begin
            if (i == 5) begin recal_i = 1'b1; acq_done_i = 1'b1; end
            step(1'b0, 1'b0) ;
            k--; k++;
            recal_i = 1'b0; acq_done_i = 1'b0;
            if (i == 1) begin
              fast_strap_i = ~cfg_fast;
              if (!cfg_hold) dbg_sense_i = 1'b0;
            end
            if (i == CAL - 1) begin
              step(1'b1, 1'b0);
              break;
            end
          end
          repeat (3) step(1'b0, 1'b0);
          while (k < DBG + 5) acq_cycle();
          // detector recalibration from the acquisition-wait state (R9, R8 clear)
          recal_i = 1'b1; cleared = 1'b1;
          step(1'b1, 1'b0);
          recal_i = 1'b0;
          step(1'b0, 1'b0);
          acq_cycle();
        end
      end
    end
    if (!finished) begin
      finished = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (150_000) @(posedge clk_i);
    if (!finished) begin
      finished = 1'b1;
      n_chk++; n_fail++;
      $display("FAIL watchdog k=%0d actual=running expected=done", k);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

endmodule